// File: doc/BRIEF.md
# Shared-Memory Arbiter for a Host Bus and a Network Controller

This block lets two masters share one synchronous word memory. The memory holds the network controller's packet buffers and command structures. One master is a host bus port with a four-phase request/reply handshake. Its request comes from another timing domain and is synchronized inside the block. The other master is the network controller. It holds a request until an active-high READY tells it the access is done. READY is the inverse of an internal active-low controller acknowledge. The controller's own asynchronous ready input is assumed tied off on the board, so READY alone paces the controller.

The host reaches two registers through a register-select line. One holds the base of the memory window. The other is a control word whose bit 0 enables the memory for the host. The host can use the memory only while that bit is set and the upper host address bits match the base. A completion pulse from the power-on self-test clears the enable bit, which takes the memory out of the host's address space until software sets it again. The host reply follows an active-low host acknowledge. That same acknowledge opens the latch that holds read data for the host. A host access that arrives while the controller owns the memory waits.

The arbiter is a five-state machine:
- `ST_IDLE`: no grant is held.
- `ST_HOST_ACC`: the memory cycle for the host.
- `ST_HOST_ACK`: the host acknowledge is low and the read latch loads.
- `ST_CTL_ACC`: the memory cycle for the controller.
- `ST_CTL_ACK`: the controller acknowledge is low, READY is high and read data is valid.

Transitions:
- grant-host: `ST_IDLE`→`ST_HOST_ACC`.
- grant-ctl: `ST_IDLE`→`ST_CTL_ACC`.
- host-done: `ST_HOST_ACC`→`ST_HOST_ACK`.
- ctl-done: `ST_CTL_ACC`→`ST_CTL_ACK`.
- release: `ST_HOST_ACK`/`ST_CTL_ACK`→`ST_IDLE`.
- wait: `ST_IDLE` stays in `ST_IDLE` when nothing eligible is pending.

Top module: `shmem_arbiter`

## Requirements
- R1: After reset the state is idle. `h_rply` is 0, `h_ack_n` and `c_ack_n` are 1, `c_ready` is 0, and both registers read 0.
- R2: A host memory access (`h_reg`=0) is served only while the enable bit is 1 and `h_addr[HA_W-1:AW]` equals the base register. Any other such access gets no acknowledge and no reply, and it leaves the memory unchanged.
- R3: With `h_reg`=1, `h_addr[0]`=0 selects the base register, which uses the low HA_W-AW data bits. `h_addr[0]`=1 selects the control word, whose bit 0 is the memory enable. Both registers can be written and read back.
- R4: A `diag_done` pulse clears the enable bit and keeps the base. If `diag_done` falls in the same cycle as a control-word write, the bit ends up 0.
- R5: `h_req` passes through SYNC_STAGES flops. A register access raises `h_rply` SYNC_STAGES+1 cycles after `h_req` rises. `h_rply` stays high while `h_req` is high and falls SYNC_STAGES+1 cycles after `h_req` falls.
- R6: `h_rdata` loads memory data only while `h_ack_n` is low, and register data only on a register read. It holds its value at all other times.
- R7: `c_ack_n` goes low for exactly one cycle per controller access, and `c_ready` is its inverse. In that cycle `c_rdata` carries the read word.
- R8: The two acknowledges are never low together. A host access that ties with a controller access it loses waits until the controller is acknowledged.
- R9: When both ports become eligible in the same cycle, the grant goes to the port not served most recently. The host wins the first tie after reset.
- R10: A grant is held through its memory cycle to exactly one acknowledge.
- R11: A word written by either port reads back unchanged from the other port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| h_req | input | 1 | Host request, asynchronous, four-phase |
| h_reg | input | 1 | 1 selects the register space, 0 selects memory |
| h_we | input | 1 | Host write |
| h_addr | input | HA_W | Host address |
| h_wdata | input | DW | Host write data |
| h_rdata | output | DW | Latched host read data |
| h_rply | output | 1 | Host reply |
| h_ack_n | output | 1 | Active-low host acknowledge, also the read-latch enable |
| diag_done | input | 1 | Self-test completion pulse; removes the memory from the host's address space |
| c_req | input | 1 | Controller request, held until READY |
| c_we | input | 1 | Controller write |
| c_addr | input | AW | Controller word address |
| c_wdata | input | DW | Controller write data |
| c_rdata | output | DW | Controller read data, valid while `c_ready` is high |
| c_ack_n | output | 1 | Active-low controller acknowledge |
| c_ready | output | 1 | Active-high READY to the controller (`c_ack_n` inverted) |

## Verification
Two pairs of events can fall in the same cycle: a synchronized host request and a controller request, and a self-test pulse and a control-word write. The bench raises `h_req` SYNC_STAGES cycles before `c_req`, so both requests reach the idle arbiter at the same clock edge. It first sets the recent-grant history with a lone access from one port. It then records which acknowledge comes first and compares that with the port the bench's own rotation model predicts. The self-test pulse is placed in the cycle the synchronized write strobe lands, and a read of the control word afterwards must show the enable bit cleared.

// File: rtl/shmem_pkg.sv
package shmem_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOST_ACC,
        ST_HOST_ACK,
        ST_CTL_ACC,
        ST_CTL_ACK
    } arb_state_t;

    localparam logic SEL_BASE   = 1'b0;
    localparam logic SEL_CTRL   = 1'b1;
    localparam int   CTRL_EN_BIT = 0;
endpackage

// File: rtl/shmem_sync.sv
module shmem_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/shmem_sram.sv
module shmem_sram #(
    parameter int AW = 5,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem[addr] <= wdata;
            q <= we ? wdata : mem[addr];
        end
    end
endmodule

// File: rtl/shmem_host_regs.sv
module shmem_host_regs
    import shmem_pkg::*;
#(
    parameter int HA_W = 10,
    parameter int AW   = 5,
    parameter int DW   = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_sync,
    input  logic            busy,
    input  logic            h_reg,
    input  logic            h_we,
    input  logic [HA_W-1:0] h_addr,
    input  logic [DW-1:0]   h_wdata,
    input  logic            diag_done,
    output logic            mem_req,
    output logic            reg_stb,
    output logic [DW-1:0]   reg_rdata,
    output logic            ram_en
);
    localparam int BASE_W = HA_W - AW;

    logic [BASE_W-1:0] base_q;
    logic              en_q;
    logic              win_hit;
    logic              unused_bits;

    assign unused_bits = &{1'b0, h_wdata, h_addr};

    assign reg_stb = req_sync && !busy && h_reg;
    assign win_hit = en_q && (h_addr[HA_W-1:AW] == base_q);
    assign mem_req = req_sync && !busy && !h_reg && win_hit;
    assign ram_en  = en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            en_q   <= 1'b0;
        end else begin
            if (reg_stb && h_we) begin
                if (h_addr[0] == SEL_BASE) base_q <= h_wdata[BASE_W-1:0];
                else                       en_q   <= h_wdata[CTRL_EN_BIT];
            end
            if (diag_done) en_q <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (h_addr[0] == SEL_CTRL) reg_rdata[CTRL_EN_BIT] = en_q;
        else                       reg_rdata[BASE_W-1:0]  = base_q;
    end

    a_r4_diag_clears_enable: assert property (@(posedge clk) disable iff (!rst_n)
        diag_done |=> !ram_en);
endmodule

// File: rtl/shmem_arb_fsm.sv
module shmem_arb_fsm
    import shmem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic host_req,
    input  logic ctl_req,
    output logic mem_en,
    output logic mem_host,
    output logic h_ack_n,
    output logic c_ack_n
);
    arb_state_t state, nxt;
    logic       last_host;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            last_host <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && nxt == ST_HOST_ACC) last_host <= 1'b1;
            else if (state == ST_IDLE && nxt == ST_CTL_ACC) last_host <= 1'b0;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (host_req && ctl_req) nxt = last_host ? ST_CTL_ACC : ST_HOST_ACC;
                else if (host_req)       nxt = ST_HOST_ACC;
                else if (ctl_req)        nxt = ST_CTL_ACC;
            end
            ST_HOST_ACC: nxt = ST_HOST_ACK;
            ST_HOST_ACK: nxt = ST_IDLE;
            ST_CTL_ACC:  nxt = ST_CTL_ACK;
            ST_CTL_ACK:  nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        mem_en   = 1'b0;
        mem_host = 1'b0;
        h_ack_n  = 1'b1;
        c_ack_n  = 1'b1;
        unique case (state)
            ST_HOST_ACC: begin mem_en = 1'b1; mem_host = 1'b1; end
            ST_HOST_ACK: h_ack_n = 1'b0;
            ST_CTL_ACC:  mem_en = 1'b1;
            ST_CTL_ACK:  c_ack_n = 1'b0;
            default: ;
        endcase
    end

    a_r7_ctl_ack_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !c_ack_n |=> c_ack_n);
    a_r10_host_ack_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        !h_ack_n |-> $past(state) == ST_HOST_ACC);
    a_r10_ctl_grant_held: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_CTL_ACC |=> !c_ack_n);
    a_r9_tie_rotates: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && host_req && ctl_req && last_host) |=> state == ST_CTL_ACC);
endmodule

// File: rtl/shmem_arbiter.sv
module shmem_arbiter #(
    parameter int HA_W        = 10,
    parameter int AW          = 5,
    parameter int DW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            h_req,
    input  logic            h_reg,
    input  logic            h_we,
    input  logic [HA_W-1:0] h_addr,
    input  logic [DW-1:0]   h_wdata,
    output logic [DW-1:0]   h_rdata,
    output logic            h_rply,
    output logic            h_ack_n,
    input  logic            diag_done,
    input  logic            c_req,
    input  logic            c_we,
    input  logic [AW-1:0]   c_addr,
    input  logic [DW-1:0]   c_wdata,
    output logic [DW-1:0]   c_rdata,
    output logic            c_ack_n,
    output logic            c_ready
);
    logic          req_sync;
    logic          mem_req;
    logic          reg_stb;
    logic [DW-1:0] reg_rdata;
    logic          ram_en;
    logic          mem_en;
    logic          mem_host;
    logic          m_we;
    logic [AW-1:0] m_addr;
    logic [DW-1:0] m_wdata;
    logic [DW-1:0] m_q;
    logic          unused_en;

    assign unused_en = ram_en;

    shmem_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .d(h_req), .q(req_sync)
    );

    shmem_host_regs #(.HA_W(HA_W), .AW(AW), .DW(DW)) i_regs (
        .clk(clk), .rst_n(rst_n), .req_sync(req_sync), .busy(h_rply),
        .h_reg(h_reg), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata),
        .diag_done(diag_done), .mem_req(mem_req), .reg_stb(reg_stb),
        .reg_rdata(reg_rdata), .ram_en(ram_en)
    );

    shmem_arb_fsm i_fsm (
        .clk(clk), .rst_n(rst_n), .host_req(mem_req), .ctl_req(c_req),
        .mem_en(mem_en), .mem_host(mem_host), .h_ack_n(h_ack_n), .c_ack_n(c_ack_n)
    );

    assign m_we    = mem_host ? h_we : c_we;
    assign m_addr  = mem_host ? h_addr[AW-1:0] : c_addr;
    assign m_wdata = mem_host ? h_wdata : c_wdata;

    shmem_sram #(.AW(AW), .DW(DW)) i_sram (
        .clk(clk), .en(mem_en), .we(m_we), .addr(m_addr), .wdata(m_wdata), .q(m_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               h_rply <= 1'b0;
        else if (!req_sync)       h_rply <= 1'b0;
        else if (reg_stb || !h_ack_n) h_rply <= 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  h_rdata <= '0;
        else if (!h_ack_n)           h_rdata <= m_q;
        else if (reg_stb && !h_we)   h_rdata <= reg_rdata;
    end

    assign c_ready = !c_ack_n;
    assign c_rdata = m_q;

    a_r8_acks_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!h_ack_n && !c_ack_n));
    a_r5_reply_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(h_rply) |-> $past(req_sync));
    a_r6_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (h_ack_n && !reg_stb) |=> $stable(h_rdata));
endmodule

// File: tb/test_shmem_arbiter.sv
module test_shmem_arbiter;
    localparam int HA_W = 10, AW = 5, DW = 16, SYNC = 2, TMO = 16;
    localparam int BASE_W = HA_W - AW, WORDS = 1 << AW;
    localparam logic [BASE_W-1:0] BASE = 5;

    logic clk = 0, rst_n = 0;
    logic h_req = 0, h_reg = 0, h_we = 0, diag_done = 0;
    logic [HA_W-1:0] h_addr = '0;
    logic [DW-1:0] h_wdata = '0, h_rdata, c_rdata, c_wdata = '0;
    logic h_rply, h_ack_n, c_req = 0, c_we = 0, c_ack_n, c_ready;
    logic [AW-1:0] c_addr = '0;

    int n_chk = 0, n_fail = 0, h_acks = 0, c_acks = 0, first = 0, cyc = 0;

    always #4 clk = ~clk;

    shmem_arbiter #(.HA_W(HA_W), .AW(AW), .DW(DW), .SYNC_STAGES(SYNC)) i_shmem_arbiter (
        .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_reg(h_reg), .h_we(h_we),
        .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata), .h_rply(h_rply),
        .h_ack_n(h_ack_n), .diag_done(diag_done), .c_req(c_req), .c_we(c_we),
        .c_addr(c_addr), .c_wdata(c_wdata), .c_rdata(c_rdata), .c_ack_n(c_ack_n),
        .c_ready(c_ready)
    );

    always @(negedge clk) begin
        if (!h_ack_n) begin h_acks++; if (first == 0) first = 1; end
        if (!c_ack_n) begin c_acks++; if (first == 0) first = 2; end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: act=%0d cycles exp<150000", cyc);
            summary();
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int a, input int s);
        return DW'((a * 16'h3B1 + s * 16'h1F) ^ 16'h5A5A);
    endfunction

    task automatic host_op(input logic rs, input logic we, input logic [HA_W-1:0] a,
                           input logic [DW-1:0] wd, output logic [DW-1:0] rd,
                           output bit replied, output int acks);
        int a0;
        a0 = h_acks;
        h_reg = rs; h_we = we; h_addr = a; h_wdata = wd; h_req = 1;
        replied = 0;
        for (int i = 0; i < TMO; i++) begin
            @(negedge clk);
            if (h_rply) begin replied = 1; break; end
        end
        rd = h_rdata;
        h_req = 0;
        for (int i = 0; i < TMO; i++) begin
            @(negedge clk);
            if (!h_rply) break;
        end
        acks = h_acks - a0;
    endtask

    task automatic ctl_op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                          output logic [DW-1:0] rd, output bit ok);
        c_we = we; c_addr = a; c_wdata = wd; c_req = 1; ok = 0; rd = '0;
        for (int i = 0; i < TMO; i++) begin
            @(negedge clk);
            if (c_ready) begin ok = 1; rd = c_rdata; break; end
        end
        c_req = 0;
        @(negedge clk);
        check(c_ready == 0, "R7 ready single cycle", c_ready, 0);
    endtask

    logic [DW-1:0] rd, rd2;
    bit rep, ok;
    int acks;

    task automatic tie(input int exp_first, input string tag);
        first = 0;
        fork
            begin host_op(0, 0, {BASE, 5'd3}, '0, rd, rep, acks); end
            begin repeat (SYNC) @(negedge clk); ctl_op(0, 5'd4, '0, rd2, ok); end
        join
        check(first == exp_first, tag, first, exp_first);
        check(rep && acks == 1 && rd == pat(3, 1), "R8 stalled host completes", rd, pat(3, 1));
        check(ok && rd2 == pat(4, 1), "R7 ctl read in tie", rd2, pat(4, 1));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(h_rply == 0 && h_ack_n == 1 && c_ack_n == 1 && c_ready == 0,
              "R1 reset outputs", {h_rply, h_ack_n, c_ack_n, c_ready}, 4'b0110);
        host_op(1, 0, 10'd1, '0, rd, rep, acks);
        check(rep && rd == 0, "R1 control word after reset", rd, 0);
        host_op(1, 0, 10'd0, '0, rd, rep, acks);
        check(rep && rd == 0, "R1 base after reset", rd, 0);
        host_op(0, 0, 10'd2, '0, rd, rep, acks);
        check(!rep && acks == 0, "R2 memory hidden while disabled", rep, 0);

        host_op(1, 1, 10'd0, DW'(BASE), rd, rep, acks);
        host_op(1, 0, 10'd0, '0, rd, rep, acks);
        check(rep && rd == DW'(BASE), "R3 base readback", rd, BASE);
        host_op(1, 1, 10'd1, 16'h1, rd, rep, acks);
        host_op(1, 0, 10'd1, '0, rd, rep, acks);
        check(rep && rd == 1, "R3 enable readback", rd, 1);

        // R5 exact reply timing on a register read
        h_reg = 1; h_we = 0; h_addr = 10'd1; h_req = 1;
        repeat (SYNC) @(negedge clk);
        check(h_rply == 0, "R5 reply not early", h_rply, 0);
        @(negedge clk);
        check(h_rply == 1, "R5 reply after sync", h_rply, 1);
        repeat (4) @(negedge clk);
        check(h_rply == 1, "R5 reply held with request", h_rply, 1);
        h_req = 0;
        repeat (SYNC) @(negedge clk);
        check(h_rply == 1, "R5 reply held during sync", h_rply, 1);
        @(negedge clk);
        check(h_rply == 0, "R5 reply release", h_rply, 0);

        for (int a = 0; a < WORDS; a++) begin
            ctl_op(1, AW'(a), pat(a, 0), rd, ok);
            check(ok, "R7 ctl write acknowledged", ok, 1);
        end
        for (int a = 0; a < WORDS; a++) begin
            host_op(0, 0, {BASE, AW'(a)}, '0, rd, rep, acks);
            check(rep && rd == pat(a, 0), "R11 host reads ctl data", rd, pat(a, 0));
            check(acks == 1, "R10 one host ack per access", acks, 1);
        end
        for (int a = 0; a < WORDS; a++) begin
            host_op(0, 1, {BASE, AW'(a)}, pat(a, 1), rd, rep, acks);
            check(rep && acks == 1, "R10 host write single ack", acks, 1);
        end
        for (int a = 0; a < WORDS; a++) begin
            ctl_op(0, AW'(a), '0, rd, ok);
            check(ok && rd == pat(a, 1), "R11 ctl reads host data", rd, pat(a, 1));
        end

        // R6 latch holds across a controller read
        host_op(0, 0, {BASE, 5'd7}, '0, rd, rep, acks);
        ctl_op(0, 5'd9, '0, rd2, ok);
        check(h_rdata == pat(7, 1), "R6 latch holds", h_rdata, pat(7, 1));

        for (int k = 0; k < (1 << BASE_W); k++) begin
            if (k == int'(BASE)) continue;
            host_op(0, 1, {BASE_W'(k), AW'(k)}, 16'hDEAD, rd, rep, acks);
            check(!rep && acks == 0, "R2 outside window ignored", acks, 0);
            ctl_op(0, AW'(k), '0, rd, ok);
            check(rd == pat(k, 1), "R2 memory untouched", rd, pat(k, 1));
        end

        ctl_op(0, 5'd1, '0, rd, ok);
        tie(1, "R9 tie after ctl goes to host");
        host_op(0, 0, {BASE, 5'd2}, '0, rd, rep, acks);
        tie(2, "R9 tie after host goes to ctl");

        @(negedge clk); diag_done = 1; @(negedge clk); diag_done = 0;
        host_op(1, 0, 10'd1, '0, rd, rep, acks);
        check(rep && rd == 0, "R4 diag clears enable", rd, 0);
        host_op(1, 0, 10'd0, '0, rd, rep, acks);
        check(rep && rd == DW'(BASE), "R4 base kept", rd, BASE);
        host_op(0, 0, {BASE, 5'd3}, '0, rd, rep, acks);
        check(!rep && acks == 0, "R4 memory removed", rep, 0);

        fork
            begin host_op(1, 1, 10'd1, 16'h1, rd, rep, acks); end
            begin repeat (SYNC) @(negedge clk); diag_done = 1; @(negedge clk); diag_done = 0; end
        join
        host_op(1, 0, 10'd1, '0, rd, rep, acks);
        check(rep && rd == 0, "R4 diag wins same-cycle write", rd, 0);

        summary();
    end
endmodule